// File: doc/BRIEF.md
# Store Unit Phase Sequencer

This block steps the control side of a store computation unit through four phases, each opened by a grant from the scoreboard. An issue loads the store opcode, marks the unit busy and asks for an operand read. The read grant loads the base operand and the store data, then asks for an address slot. The address grant latches the effective address, which is the base operand plus the sign-extended immediate in the low bits of the opcode, then asks for a write slot. The write grant latches the store data as the result, clears busy and leaves the unit free for the next issue.

Each phase asserts exactly one request line. A grant that does not match the current phase has no effect, and an issue that arrives while the unit is busy is dropped. All held values come out on ports for the memory side, which lies outside this block, as does the arbitration that produces the grants.

Top module: `st_phase_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves busy_o, req_rd_o, req_addr_o and req_wr_o low and all held outputs (opc_o, opa_o, opb_o, addr_o, wdata_o) zero.
- R2: An issue_i while idle loads opcode_i into opc_o, and from the next cycle busy_o and req_rd_o are high.
- R3: A go_rd_i while req_rd_o is high loads opa_i into opa_o and opb_i into opb_o; in the next cycle req_rd_o is low and req_addr_o is high.
- R4: A go_addr_i while req_addr_o is high loads addr_o with opa_o plus opc_o[IMM_W-1:0] sign-extended to DW bits (bit IMM_W-1 is the sign), modulo 2^DW; in the next cycle req_addr_o is low and req_wr_o is high.
- R5: A go_wr_i while req_wr_o is high loads opb_o into wdata_o; in the next cycle busy_o and every request line are low.
- R6: At most one request line is high in any cycle, and busy_o is high exactly when one of them is.
- R7: A grant whose request line is low changes no output: the requests, busy_o and the held values stay as they were.
- R8: An issue_i while busy_o is high is ignored: opc_o and the phase are unchanged.
- R9: An issue_i in the cycle right after a write grant is accepted, so stores run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe from the scoreboard |
| opcode_i | input | OPC_W | Store opcode; low IMM_W bits hold the signed offset |
| go_rd_i | input | 1 | Operand-read grant |
| opa_i | input | DW | Base operand presented with the read grant |
| opb_i | input | DW | Store data operand presented with the read grant |
| go_addr_i | input | 1 | Address grant |
| go_wr_i | input | 1 | Write grant |
| busy_o | output | 1 | Unit holds a store in progress |
| req_rd_o | output | 1 | Request for an operand read |
| req_addr_o | output | 1 | Request for the address phase |
| req_wr_o | output | 1 | Request for the write phase |
| opc_o | output | OPC_W | Held opcode |
| opa_o | output | DW | Held base operand |
| opb_o | output | DW | Held store data operand |
| addr_o | output | DW | Held effective address |
| wdata_o | output | DW | Held store result |

## Verification
Every result here is due one rising edge after its stimulus: a grant or issue seen at an edge shows up on the request lines, busy_o and the matching held register straight after that edge, and nothing is computed across two edges. The bench drives inputs just after a falling edge and samples on the following falling edge, so every check lands half a cycle after the one edge that can have changed the output. Stall cycles with no grant, out-of-phase grants and a late issue are each followed by a sample on the next falling edge, which shows that the state did not move.

// File: rtl/st_seq_pkg.sv
package st_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_ADDR  = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;
endpackage

// File: rtl/st_phase_ctl.sv
module st_phase_ctl
  import st_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   issue_i,
  input  logic   go_rd_i,
  input  logic   go_addr_i,
  input  logic   go_wr_i,
  output phase_t phase_o,
  output logic   take_issue_o,
  output logic   take_rd_o,
  output logic   take_addr_o,
  output logic   take_wr_o
);
  phase_t phase_q;
  phase_t phase_d;

  // A grant counts only in the phase that asked for it.
  assign take_issue_o = issue_i   && (phase_q == PH_IDLE);
  assign take_rd_o    = go_rd_i   && (phase_q == PH_READ);
  assign take_addr_o  = go_addr_i && (phase_q == PH_ADDR);
  assign take_wr_o    = go_wr_i   && (phase_q == PH_WRITE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (take_issue_o) phase_d = PH_READ;
      PH_READ:  if (take_rd_o)    phase_d = PH_ADDR;
      PH_ADDR:  if (take_addr_o)  phase_d = PH_WRITE;
      PH_WRITE: if (take_wr_o)    phase_d = PH_IDLE;
      default:                    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/st_hold_reg.sv
module st_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/st_addr_gen.sv
module st_addr_gen #(
  parameter int DW    = 32,
  parameter int IMM_W = 12
) (
  input  logic [DW-1:0]    base_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [DW-1:0]    ea_o
);
  localparam int EXT_W = DW - IMM_W;

  function automatic logic [DW-1:0] ea_calc(input logic [DW-1:0] base,
                                            input logic [IMM_W-1:0] imm);
    logic [DW-1:0] ext;
    ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    return base + ext;
  endfunction

  assign ea_o = ea_calc(base_i, imm_i);
endmodule

// File: rtl/st_phase_seq.sv
module st_phase_seq
  import st_seq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OPC_W = 16,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             go_rd_i,
  input  logic [DW-1:0]    opa_i,
  input  logic [DW-1:0]    opb_i,
  input  logic             go_addr_i,
  input  logic             go_wr_i,
  output logic             busy_o,
  output logic             req_rd_o,
  output logic             req_addr_o,
  output logic             req_wr_o,
  output logic [OPC_W-1:0] opc_o,
  output logic [DW-1:0]    opa_o,
  output logic [DW-1:0]    opb_o,
  output logic [DW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o
);
  phase_t        phase;
  logic          take_issue;
  logic          take_rd;
  logic          take_addr;
  logic          take_wr;
  logic [DW-1:0] ea;

  st_phase_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue_i),
    .go_rd_i     (go_rd_i),
    .go_addr_i   (go_addr_i),
    .go_wr_i     (go_wr_i),
    .phase_o     (phase),
    .take_issue_o(take_issue),
    .take_rd_o   (take_rd),
    .take_addr_o (take_addr),
    .take_wr_o   (take_wr)
  );

  st_hold_reg #(.W(OPC_W)) u_opc (
    .clk(clk), .rst(rst), .load_i(take_issue), .d_i(opcode_i), .q_o(opc_o));
  st_hold_reg #(.W(DW)) u_opa (
    .clk(clk), .rst(rst), .load_i(take_rd), .d_i(opa_i), .q_o(opa_o));
  st_hold_reg #(.W(DW)) u_opb (
    .clk(clk), .rst(rst), .load_i(take_rd), .d_i(opb_i), .q_o(opb_o));

  st_addr_gen #(.DW(DW), .IMM_W(IMM_W)) u_agen (
    .base_i(opa_o),
    .imm_i (opc_o[IMM_W-1:0]),
    .ea_o  (ea)
  );

  st_hold_reg #(.W(DW)) u_addr (
    .clk(clk), .rst(rst), .load_i(take_addr), .d_i(ea), .q_o(addr_o));
  st_hold_reg #(.W(DW)) u_res (
    .clk(clk), .rst(rst), .load_i(take_wr), .d_i(opb_o), .q_o(wdata_o));

  assign req_rd_o   = (phase == PH_READ);
  assign req_addr_o = (phase == PH_ADDR);
  assign req_wr_o   = (phase == PH_WRITE);
  assign busy_o     = (phase != PH_IDLE);
endmodule

// File: rtl/st_phase_seq_chk.sv
module st_phase_seq_chk #(
  parameter int DW    = 32,
  parameter int OPC_W = 16,
  parameter int IMM_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic             go_rd_i,
  input logic             go_addr_i,
  input logic             go_wr_i,
  input logic             take_issue,
  input logic             take_rd,
  input logic             take_addr,
  input logic             take_wr,
  input logic             busy_o,
  input logic             req_rd_o,
  input logic             req_addr_o,
  input logic             req_wr_o,
  input logic [OPC_W-1:0] opc_o,
  input logic [DW-1:0]    opa_o,
  input logic [DW-1:0]    opb_o,
  input logic [DW-1:0]    addr_o,
  input logic [DW-1:0]    wdata_o
);
  logic signed [DW-1:0] imm_s;
  logic [DW-1:0]        ea_exp;
  assign imm_s  = DW'($signed(opc_o[IMM_W-1:0]));
  assign ea_exp = opa_o + imm_s;

  assert_req_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_rd_o, req_addr_o, req_wr_o}));
  assert_busy_req_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o == (req_rd_o || req_addr_o || req_wr_o));
  assert_issue_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !busy_o) |=> (req_rd_o && busy_o && opc_o == $past(opcode_i)));
  assert_read_R3: assert property (@(posedge clk) disable iff (rst)
    (go_rd_i && req_rd_o) |=> (req_addr_o && !req_rd_o));
  assert_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (go_addr_i && req_addr_o) |=> (req_wr_o && addr_o == $past(ea_exp)));
  assert_write_R5: assert property (@(posedge clk) disable iff (rst)
    (go_wr_i && req_wr_o) |=> (!busy_o && wdata_o == $past(opb_o)));
  assert_busy_issue_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(opc_o));
  assert_no_take_R7: assert property (@(posedge clk) disable iff (rst)
    !(take_issue || take_rd || take_addr || take_wr) |=>
      ($stable(busy_o) && $stable(req_rd_o) && $stable(req_addr_o) && $stable(req_wr_o)
       && $stable(opa_o) && $stable(opb_o) && $stable(addr_o) && $stable(wdata_o)));
  assert_b2b_R9: assert property (@(posedge clk) disable iff (rst)
    (go_wr_i && req_wr_o) |=> !busy_o);
endmodule

bind st_phase_seq st_phase_seq_chk #(.DW(DW), .OPC_W(OPC_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue_i   (issue_i),
  .opcode_i  (opcode_i),
  .go_rd_i   (go_rd_i),
  .go_addr_i (go_addr_i),
  .go_wr_i   (go_wr_i),
  .take_issue(take_issue),
  .take_rd   (take_rd),
  .take_addr (take_addr),
  .take_wr   (take_wr),
  .busy_o    (busy_o),
  .req_rd_o  (req_rd_o),
  .req_addr_o(req_addr_o),
  .req_wr_o  (req_wr_o),
  .opc_o     (opc_o),
  .opa_o     (opa_o),
  .opb_o     (opb_o),
  .addr_o    (addr_o),
  .wdata_o   (wdata_o)
);

// File: tb/st_phase_seq_bench.sv
module st_phase_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 32;
  localparam int OPC_W = 16;
  localparam int IMM_W = 12;
  localparam int NVEC  = 4;

  // each vector: opcode, base operand, store data
  localparam logic [OPC_W+2*DW-1:0] VEC [NVEC] = '{
    {16'hA004, 32'h1000_0000, 32'hDEAD_BEEF},
    {16'h3FFC, 32'h0000_0002, 32'h1234_5678},
    {16'h5800, 32'h0000_0000, 32'hCAFE_F00D},
    {16'h07FF, 32'hFFFF_FFFF, 32'h0BAD_0BAD}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             issue_i = 1'b0;
  logic [OPC_W-1:0] opcode_i = '0;
  logic             go_rd_i = 1'b0;
  logic [DW-1:0]    opa_i = '0;
  logic [DW-1:0]    opb_i = '0;
  logic             go_addr_i = 1'b0;
  logic             go_wr_i = 1'b0;
  logic             busy_o, req_rd_o, req_addr_o, req_wr_o;
  logic [OPC_W-1:0] opc_o;
  logic [DW-1:0]    opa_o, opb_o, addr_o, wdata_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  st_phase_seq #(.DW(DW), .OPC_W(OPC_W), .IMM_W(IMM_W)) u_st_phase_seq (
    .clk(clk), .rst(rst), .issue_i(issue_i), .opcode_i(opcode_i),
    .go_rd_i(go_rd_i), .opa_i(opa_i), .opb_i(opb_i),
    .go_addr_i(go_addr_i), .go_wr_i(go_wr_i),
    .busy_o(busy_o), .req_rd_o(req_rd_o), .req_addr_o(req_addr_o),
    .req_wr_o(req_wr_o), .opc_o(opc_o), .opa_o(opa_o), .opb_o(opb_o),
    .addr_o(addr_o), .wdata_o(wdata_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // busy plus request lines packed as {busy, rd, addr, wr}
  task automatic chk_ctl(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {busy_o, req_rd_o, req_addr_o, req_wr_o};
    chk(act == exp, tag, DW'(act), DW'(exp));
  endtask

  function automatic logic [DW-1:0] exp_addr(input logic [DW-1:0] base,
                                             input logic [OPC_W-1:0] opc);
    logic [DW-1:0] off;
    off = DW'(opc[IMM_W-1:0]);
    if (opc[IMM_W-1]) off = off - (DW'(1) << IMM_W);
    return base + off;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    issue_i = 0; go_rd_i = 0; go_addr_i = 0; go_wr_i = 0;
  endtask

  // caller is just after a falling edge; ends just after a falling edge
  task automatic run_store(input logic [OPC_W-1:0] opc, input logic [DW-1:0] a,
                           input logic [DW-1:0] b, input bit b2b);
    clear_in(); issue_i = 1; opcode_i = opc;
    tick();
    chk_ctl(b2b ? "R9 issue after write" : "R2 issue ctl", 4'b1100);
    chk(opc_o == opc, "R2 opcode held", DW'(opc_o), DW'(opc));
    clear_in(); opcode_i = ~opc;
    tick();
    chk_ctl("R7 stall keeps read req", 4'b1100);
    go_rd_i = 1; opa_i = a; opb_i = b;
    tick();
    chk_ctl("R3 read ctl", 4'b1010);
    chk(opa_o == a, "R3 opa held", opa_o, a);
    chk(opb_o == b, "R3 opb held", opb_o, b);
    clear_in(); opa_i = ~a; opb_i = ~b; go_addr_i = 1;
    tick();
    chk_ctl("R4 addr ctl", 4'b1001);
    chk(addr_o == exp_addr(a, opc), "R4 address", addr_o, exp_addr(a, opc));
    clear_in(); go_wr_i = 1;
    tick();
    chk_ctl("R5 write ctl", 4'b0000);
    chk(wdata_o == b, "R5 result", wdata_o, b);
    clear_in();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] a_keep, addr_keep, res_keep;
    tick(); tick();
    rst = 0;
    chk_ctl("R1 reset ctl", 4'b0000);
    chk(opc_o == '0 && opa_o == '0 && opb_o == '0 && addr_o == '0 && wdata_o == '0,
        "R1 reset data", opa_o | addr_o | wdata_o, '0);

    for (int i = 0; i < NVEC; i++) begin
      run_store(VEC[i][OPC_W+2*DW-1:2*DW], VEC[i][2*DW-1:DW], VEC[i][DW-1:0], i > 0);
    end

    // R7: grants in idle are ignored
    a_keep = opa_o;
    go_rd_i = 1; opa_i = 32'h5555_5555; go_addr_i = 1; go_wr_i = 1;
    tick();
    chk_ctl("R7 idle grants ctl", 4'b0000);
    chk(opa_o == a_keep, "R7 idle go_rd", opa_o, a_keep);
    clear_in();

    // R7/R8: wrong grants and a late issue during the read phase
    issue_i = 1; opcode_i = 16'h0010;
    tick();
    addr_keep = addr_o; res_keep = wdata_o;
    issue_i = 1; opcode_i = 16'h0FFF; go_addr_i = 1; go_wr_i = 1;
    tick();
    chk_ctl("R7 wrong grants in read", 4'b1100);
    chk(opc_o == 16'h0010, "R8 issue while busy", DW'(opc_o), 32'h10);
    chk(addr_o == addr_keep, "R7 addr untouched", addr_o, addr_keep);
    chk(wdata_o == res_keep, "R7 result untouched", wdata_o, res_keep);
    clear_in(); go_rd_i = 1; opa_i = 32'h0000_0100; opb_i = 32'h7777_0000;
    tick();
    issue_i = 1; opcode_i = 16'h0123; go_rd_i = 1; opa_i = 32'h9; go_wr_i = 1;
    tick();
    chk_ctl("R7 wrong grants in addr", 4'b1010);
    chk(opa_o == 32'h100, "R7 opa untouched", opa_o, 32'h100);
    chk(opc_o == 16'h0010, "R8 opcode kept", DW'(opc_o), 32'h10);
    clear_in(); go_addr_i = 1;
    tick();
    chk(addr_o == 32'h110, "R4 address +16", addr_o, 32'h110);

    // R1: reset in the write phase
    rst = 1;
    tick();
    rst = 0;
    chk_ctl("R1 mid-store reset", 4'b0000);
    chk(addr_o == '0 && opc_o == '0, "R1 mid-store data", addr_o, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule